// File: doc/BRIEF.md
# Banked PCS Register Window Translator

This block turns a clause-45 style register request (port, device number, 16-bit register number, read or write, 16-bit data) into 32-bit word transactions on a simple memory-mapped bus. Each serial-lane port that owns a register window is reached through a 256-word window. The top word of every window selects a bank. Each logical access therefore becomes two dependent bus transactions. The first writes the bank number into the bank-select word. The second reads or writes the addressed word inside the window.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel. A request is taken when `req_valid` and `req_ready` are both high on a rising edge. The request fields need only be valid in that cycle. `req_ready` stays low from acceptance until the response has been taken, so only one request is ever in flight. The response channel honours back-pressure: `rsp_valid`, `rsp_rdata` and `rsp_err` hold steady until `rsp_ready` is seen high. Requests that cannot be mapped are answered with an error and cause no bus traffic.

The bus side is a plain master. It keeps `bus_req` high with a fixed address, write enable and write data until the slave pulses `bus_ack`. `bus_err` is sampled in the cycle in which `bus_ack` is high.

Top module: `pcs_window_xlate`

## Requirements
- R1: For an accepted request, the first bus transaction is a write to byte address base + 0x3FC, which is word 255 of the window. Its data is the bank number, zero-extended. The bank number is ({device, register} >> 8), where the full address is the device number placed above the 16-bit register number.
- R2: The second bus transaction goes to byte address base + 4 × (low 8 bits of the register number).
- R3: Ports 1, 2, 3 and 4 map to window bases 0x1C1400, 0x1C1800, 0x1C1C00 and 0x1C2000, in that order. A request for any other port gets `rsp_err`=1 and `rsp_rdata`=0, with no bus transaction.
- R4: A request whose register number has a low byte of 0xFF gets an error response with no bus transaction. A low byte of 0xFE is still served.
- R5: A request with `req_has_dev`=0 (no device number given) gets an error response with no bus transaction.
- R6: A read returns the low 16 bits of the second transaction's read data on `rsp_rdata`, with `rsp_err`=0.
- R7: A write drives `bus_we`=1 in the second transaction, with the 16-bit data zero-extended to 32 bits. Its response has `rsp_rdata`=0.
- R8: If the bank-select write ends with `bus_err`=1, the request is aborted. The second transaction is not issued and the response has `rsp_err`=1.
- R9: If the second transaction ends with `bus_err`=1, the response has `rsp_err`=1.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_addr`, `bus_we` and `bus_wdata` are held, and `bus_req` stays high in the next cycle.
- R11: `req_ready` is low from the cycle after acceptance until the response is taken. While `rsp_valid` is high and `rsp_ready` is low, the response and its data are held.
- R12: During reset, `req_ready`=1, `rsp_valid`=0 and `bus_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_port | input | 4 | Target port number |
| req_has_dev | input | 1 | 1 when a device number is given |
| req_devnum | input | 5 | Device number |
| req_regnum | input | 16 | Register number within the device |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 16 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Request rejected or bus error |
| bus_req | output | 1 | Bus transaction pending |
| bus_addr | output | 24 | Byte address |
| bus_we | output | 1 | 1 = write transaction |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Slave completes the transaction |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_err | input | 1 | Error status, valid with bus_ack |

## Verification
A corrupted sequencer state shows at the bus within one cycle. Typical signs are a second transaction with no bank write before it, an address that is not the bank word at the start of a request, or a transaction issued for a rejected request. A stuck state keeps `req_ready` low and is caught by the per-request response timeout. A wrong base or offset appears in the logged address of the same transaction. A lost latch of the response shows as data or error changing while the response is stalled, in the cycle after the change.

// File: rtl/pcs_win_pkg.sv
package pcs_win_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BANK = 2'd1,
    ST_XFER = 2'd2,
    ST_RESP = 2'd3
  } xlate_state_e;
endpackage

// File: rtl/pcs_port_map.sv
module pcs_port_map #(
  parameter int PORT_W = 4,
  parameter int BUS_AW = 24,
  parameter int N_WIN = 4,
  parameter int FIRST_PORT = 1,
  parameter logic [BUS_AW-1:0] WIN_BASE = 24'h1C1400,
  parameter logic [BUS_AW-1:0] WIN_STRIDE = 24'h000400
) (
  input  logic [PORT_W-1:0] port,
  output logic              hit,
  output logic [BUS_AW-1:0] base
);
  logic [N_WIN-1:0]             hit_vec;
  logic [N_WIN-1:0][BUS_AW-1:0] base_vec;

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    assign hit_vec[i]  = (port == PORT_W'(FIRST_PORT + i));
    assign base_vec[i] = WIN_BASE + BUS_AW'(i) * WIN_STRIDE;
  end

  always_comb begin
    base = '0;
    for (int i = 0; i < N_WIN; i++) begin
      if (hit_vec[i]) base = base | base_vec[i];
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/pcs_addr_split.sv
module pcs_addr_split #(
  parameter int DEV_W = 5,
  parameter int REG_W = 16,
  parameter int OFF_W = 8,
  localparam int FULL_W = DEV_W + REG_W,
  localparam int BANK_W = FULL_W - OFF_W
) (
  input  logic [DEV_W-1:0]  devnum,
  input  logic [REG_W-1:0]  regnum,
  output logic [BANK_W-1:0] bank,
  output logic [OFF_W-1:0]  offset,
  output logic              off_reserved
);
  logic [FULL_W-1:0] full_addr;

  assign full_addr    = {devnum, regnum};
  assign bank         = full_addr[FULL_W-1:OFF_W];
  assign offset       = full_addr[OFF_W-1:0];
  assign off_reserved = &offset;
endmodule

// File: rtl/pcs_bus_seq.sv
module pcs_bus_seq
  import pcs_win_pkg::*;
#(
  parameter int BUS_AW = 24,
  parameter int BUS_DW = 32,
  parameter int DATA_W = 16,
  parameter int BANK_W = 13,
  parameter int OFF_W = 8,
  localparam int WORD_SHIFT = $clog2(BUS_DW / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              acc_reject,
  input  logic [BUS_AW-1:0] acc_base,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bus_req,
  output logic [BUS_AW-1:0] bus_addr,
  output logic              bus_we,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [BUS_DW-1:0] bus_rdata,
  input  logic              bus_err
);
  xlate_state_e      state_q;
  logic [BUS_AW-1:0] base_q;
  logic [BANK_W-1:0] bank_q;
  logic [OFF_W-1:0]  off_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic [OFF_W-1:0]  sel_off;
  logic              unused_rdata_hi;

  assign unused_rdata_hi = ^bus_rdata[BUS_DW-1:DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      bank_q  <= '0;
      off_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          base_q  <= acc_base;
          bank_q  <= acc_bank;
          off_q   <= acc_off;
          we_q    <= acc_we;
          wdata_q <= acc_wdata;
          rdata_q <= '0;
          err_q   <= acc_reject;
          state_q <= acc_reject ? ST_RESP : ST_BANK;
        end
        ST_BANK: if (bus_ack) begin
          err_q   <= bus_err;
          state_q <= bus_err ? ST_RESP : ST_XFER;
        end
        ST_XFER: if (bus_ack) begin
          rdata_q <= we_q ? '0 : bus_rdata[DATA_W-1:0];
          err_q   <= bus_err;
          state_q <= ST_RESP;
        end
        default: if (rsp_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_off   = (state_q == ST_BANK) ? '1 : off_q;
  assign bus_req   = (state_q == ST_BANK) || (state_q == ST_XFER);
  assign bus_addr  = base_q + (BUS_AW'(sel_off) << WORD_SHIFT);
  assign bus_we    = (state_q == ST_BANK) ? 1'b1 : we_q;
  assign bus_wdata = (state_q == ST_BANK) ? BUS_DW'(bank_q) : BUS_DW'(wdata_q);
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
endmodule

// File: rtl/pcs_window_xlate.sv
module pcs_window_xlate #(
  parameter int PORT_W = 4,
  parameter int DEV_W = 5,
  parameter int REG_W = 16,
  parameter int DATA_W = 16,
  parameter int BUS_AW = 24,
  parameter int BUS_DW = 32,
  parameter int WIN_WORDS = 256,
  parameter int N_WIN = 4,
  parameter int FIRST_PORT = 1,
  parameter logic [BUS_AW-1:0] WIN_BASE = 24'h1C1400,
  parameter logic [BUS_AW-1:0] WIN_STRIDE = 24'h000400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PORT_W-1:0] req_port,
  input  logic              req_has_dev,
  input  logic [DEV_W-1:0]  req_devnum,
  input  logic [REG_W-1:0]  req_regnum,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bus_req,
  output logic [BUS_AW-1:0] bus_addr,
  output logic              bus_we,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [BUS_DW-1:0] bus_rdata,
  input  logic              bus_err
);
  localparam int OFF_W  = $clog2(WIN_WORDS);
  localparam int BANK_W = DEV_W + REG_W - OFF_W;

  logic              port_hit;
  logic [BUS_AW-1:0] port_base;
  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  offset;
  logic              off_reserved;
  logic              reject;

  pcs_port_map #(
    .PORT_W(PORT_W), .BUS_AW(BUS_AW), .N_WIN(N_WIN), .FIRST_PORT(FIRST_PORT),
    .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE)
  ) u_port_map (
    .port(req_port), .hit(port_hit), .base(port_base)
  );

  pcs_addr_split #(
    .DEV_W(DEV_W), .REG_W(REG_W), .OFF_W(OFF_W)
  ) u_addr_split (
    .devnum(req_devnum), .regnum(req_regnum), .bank(bank),
    .offset(offset), .off_reserved(off_reserved)
  );

  assign reject = !req_has_dev || !port_hit || off_reserved;

  pcs_bus_seq #(
    .BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .DATA_W(DATA_W),
    .BANK_W(BANK_W), .OFF_W(OFF_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .acc_reject(reject), .acc_base(port_base), .acc_bank(bank),
    .acc_off(offset), .acc_we(req_write), .acc_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .bus_err(bus_err)
  );
endmodule

// File: rtl/pcs_window_xlate_checker.sv
module pcs_window_xlate_checker #(
  parameter int PORT_W = 4,
  parameter int REG_W = 16,
  parameter int DATA_W = 16,
  parameter int BUS_AW = 24,
  parameter int BUS_DW = 32,
  parameter int WIN_WORDS = 256,
  parameter int N_WIN = 4,
  parameter int FIRST_PORT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PORT_W-1:0] req_port,
  input logic              req_has_dev,
  input logic [REG_W-1:0]  req_regnum,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              bus_req,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              bus_err
);
  localparam int OFF_W   = $clog2(WIN_WORDS);
  localparam int WIN_LSB = OFF_W + $clog2(BUS_DW / 8);
  localparam logic [WIN_LSB-1:0] BANK_SEL_BYTE = {{OFF_W{1'b1}}, {(WIN_LSB - OFF_W){1'b0}}};

  logic accept;
  logic port_out;
  logic unused_reg_hi;

  assign accept        = req_valid && req_ready;
  assign port_out      = (int'(req_port) < FIRST_PORT) || (int'(req_port) >= FIRST_PORT + N_WIN);
  assign unused_reg_hi = ^req_regnum[REG_W-1:OFF_W];

  assert_bank_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (bus_we && bus_addr[WIN_LSB-1:0] == BANK_SEL_BYTE));

  assert_port_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && port_out) |=> (!bus_req && rsp_valid && rsp_err));

  assert_resv_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (&req_regnum[OFF_W-1:0])) |=> (!bus_req && rsp_valid && rsp_err));

  assert_nodev_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_has_dev) |=> (!bus_req && rsp_valid && rsp_err));

  assert_bank_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_err && bus_addr[WIN_LSB-1:0] == BANK_SEL_BYTE)
    |=> (!bus_req && rsp_valid && rsp_err));

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_single_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (bus_req || rsp_valid)));
endmodule

bind pcs_window_xlate pcs_window_xlate_checker #(
  .PORT_W(PORT_W), .REG_W(REG_W), .DATA_W(DATA_W), .BUS_AW(BUS_AW),
  .BUS_DW(BUS_DW), .WIN_WORDS(WIN_WORDS), .N_WIN(N_WIN), .FIRST_PORT(FIRST_PORT)
) u_checker (.*);

// File: tb/pcs_window_xlate_bench.sv
module pcs_window_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_port = '0;
  logic        req_has_dev = 1'b0;
  logic [4:0]  req_devnum = '0;
  logic [15:0] req_regnum = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic        bus_req;
  logic [23:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        bus_err = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  // slave model configuration and transaction log
  int          lat_cfg = 0;
  int          err_at = -1;
  logic [31:0] rd_cfg = '0;
  int          wcnt = 0;
  int          txn_n = 0;
  logic [23:0] lg_addr[4];
  logic [23:0] lg_first[4];
  logic        lg_we[4];
  logic [31:0] lg_wdata[4];

  logic        got_err;
  logic [15:0] got_rdata;

  pcs_window_xlate u_pcs_window_xlate (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_base(input int p);
    return 24'h1C1400 + 24'(p - 1) * 24'h400;
  endfunction

  // bus slave: acks after lat_cfg wait cycles, logs each transaction
  initial begin
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
      end else if (bus_req) begin
        if (wcnt == 0 && txn_n < 4) lg_first[txn_n] = bus_addr;
        if (wcnt == lat_cfg) begin
          if (txn_n < 4) begin
            lg_addr[txn_n]  = bus_addr;
            lg_we[txn_n]    = bus_we;
            lg_wdata[txn_n] = bus_wdata;
          end
          bus_ack   = 1'b1;
          bus_err   = (txn_n == err_at);
          bus_rdata = rd_cfg;
          txn_n++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic run_req(input int port, input logic has_dev, input logic [4:0] dev,
                         input logic [15:0] rn, input logic we, input logic [15:0] wd,
                         input int lat, input int eat, input logic [31:0] rdv);
    lat_cfg = lat; err_at = eat; rd_cfg = rdv; txn_n = 0; wcnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_port = 4'(port); req_has_dev = has_dev;
    req_devnum = dev; req_regnum = rn; req_write = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_regnum = '0; req_wdata = '0;
    chk("R11 busy after accept", 32'(req_ready), 32'd0);
    for (int i = 0; i < 60 && !rsp_valid; i++) @(negedge clk);
    chk("R11 response arrives", 32'(rsp_valid), 32'd1);
    got_err = rsp_err; got_rdata = rsp_rdata;
    @(negedge clk);
    chk("R11 rsp held valid", 32'(rsp_valid), 32'd1);
    chk("R11 rsp data held", {15'd0, rsp_err, rsp_rdata}, {15'd0, got_err, got_rdata});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11 ready after rsp", 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset;
    chk("R12 req_ready in reset", 32'(req_ready), 32'd1);
    chk("R12 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R12 bus_req in reset", 32'(bus_req), 32'd0);
  endtask

  task automatic t_read_basic;
    // dev 5 reg 0x8045: full 0x58045, bank 0x580, offset 0x45
    run_req(1, 1'b1, 5'd5, 16'h8045, 1'b0, 16'h0, 0, -1, 32'hABCD1234);
    chk("R1 txn count", 32'(txn_n), 32'd2);
    chk("R1 bank addr", 32'(lg_addr[0]), 32'(exp_base(1) + 24'h3FC));
    chk("R1 bank we", 32'(lg_we[0]), 32'd1);
    chk("R1 bank data", lg_wdata[0], 32'h580);
    chk("R2 word addr", 32'(lg_addr[1]), 32'(exp_base(1) + 24'h45 * 4));
    chk("R6 read we", 32'(lg_we[1]), 32'd0);
    chk("R6 read data", 32'(got_rdata), 32'h1234);
    chk("R6 read err", 32'(got_err), 32'd0);
  endtask

  task automatic t_write_slow;
    // port 4, dev 31 reg 0x80E1: bank 0x1F80, offset 0xE1, three wait cycles
    run_req(4, 1'b1, 5'd31, 16'h80E1, 1'b1, 16'h0010, 3, -1, 32'hFFFFFFFF);
    chk("R3 port4 bank addr", 32'(lg_addr[0]), 32'h1C23FC);
    chk("R1 bank data dev31", lg_wdata[0], 32'h1F80);
    chk("R10 bank addr held", 32'(lg_first[0]), 32'(lg_addr[0]));
    chk("R10 word addr held", 32'(lg_first[1]), 32'(lg_addr[1]));
    chk("R2 port4 word addr", 32'(lg_addr[1]), 32'h1C2384);
    chk("R7 write we", 32'(lg_we[1]), 32'd1);
    chk("R7 write data", lg_wdata[1], 32'h0000_0010);
    chk("R7 write rsp data", 32'(got_rdata), 32'd0);
    chk("R7 write err", 32'(got_err), 32'd0);
  endtask

  task automatic t_bases;
    for (int p = 2; p <= 3; p++) begin
      run_req(p, 1'b1, 5'd1, 16'h0002, 1'b0, 16'h0, 1, -1, 32'h0000BEEF);
      chk("R3 base bank addr", 32'(lg_addr[0]), 32'(exp_base(p) + 24'h3FC));
      chk("R3 bank data dev1", lg_wdata[0], 32'h100);
      chk("R3 base word addr", 32'(lg_addr[1]), 32'(exp_base(p) + 24'h8));
      chk("R6 read data", 32'(got_rdata), 32'hBEEF);
    end
  endtask

  task automatic t_bad_ports;
    int bad[3] = '{0, 5, 15};
    foreach (bad[k]) begin
      run_req(bad[k], 1'b1, 5'd1, 16'h0010, 1'b0, 16'h0, 0, -1, 32'h1);
      chk("R3 bad port err", 32'(got_err), 32'd1);
      chk("R3 bad port rdata", 32'(got_rdata), 32'd0);
      chk("R3 bad port no bus", 32'(txn_n), 32'd0);
    end
  endtask

  task automatic t_reserved_offset;
    run_req(2, 1'b1, 5'd30, 16'h80FF, 1'b1, 16'h5555, 0, -1, 32'h1);
    chk("R4 offset FF err", 32'(got_err), 32'd1);
    chk("R4 offset FF no bus", 32'(txn_n), 32'd0);
    run_req(2, 1'b1, 5'd1, 16'h00FE, 1'b0, 16'h0, 0, -1, 32'h00007777);
    chk("R4 offset FE served", 32'(got_err), 32'd0);
    chk("R4 offset FE addr", 32'(lg_addr[1]), 32'h1C1BF8);
    chk("R4 offset FE data", 32'(got_rdata), 32'h7777);
  endtask

  task automatic t_no_device;
    run_req(1, 1'b0, 5'd1, 16'h0001, 1'b0, 16'h0, 0, -1, 32'h1);
    chk("R5 no dev err", 32'(got_err), 32'd1);
    chk("R5 no dev no bus", 32'(txn_n), 32'd0);
  endtask

  task automatic t_bank_error;
    run_req(3, 1'b1, 5'd7, 16'h0020, 1'b1, 16'h1234, 2, 0, 32'h1);
    chk("R8 bank err flag", 32'(got_err), 32'd1);
    chk("R8 no second txn", 32'(txn_n), 32'd1);
  endtask

  task automatic t_data_error;
    run_req(1, 1'b1, 5'd7, 16'h0020, 1'b0, 16'h0, 0, 1, 32'h1);
    chk("R9 data err flag", 32'(got_err), 32'd1);
    chk("R9 two txns", 32'(txn_n), 32'd2);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read_basic();
    t_write_slow();
    t_bases();
    t_bad_ports();
    t_reserved_offset();
    t_no_device();
    t_bank_error();
    t_data_error();
    t_read_basic();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end
endmodule